// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts hardware events for performance analysis. It has two 32-bit event counters. Each one chooses, through its own 8-bit selector, one line of a vector of up to 256 single-cycle event strobes. When the chosen strobe is high at a clock edge, the counter increments, provided that the current privilege level matches an enabled context. The two counters share one set of context enables (user, supervisor, hypervisor), so counting can only be started and stopped for both at once. To keep a single counter still, software selects that counter's dedicated parking code, which never counts.

Software reaches the block through a small register port. The port has a 2-bit address, a 64-bit write bus with one write strobe per 32-bit half, and a combinational read bus. Both counters sit in one 64-bit register, and each half can be written on its own. Software preloads a counter with the two's complement of a sampling period. When the counter wraps from all ones to zero, it sets a sticky overflow flag. The interrupt output is the OR of the two flags, gated by an interrupt-enable bit. Software clears the flags by writing ones to them.

The asynchronous active-low reset is synchronised inside the block, so registers leave reset two clock edges after `rst_n` rises.

Top module: `dual_ctr_pmu`

## Requirements
- R1: After reset the control register, both counters and both overflow flags read zero, and `irq` is low.
- R2: Address 1 reads `{counter 0, counter 1}`, with counter 0 in bits 63:32 and counter 1 in bits 31:0. A write to address 1 loads bits 63:32 when `wr_be[1]` is set and bits 31:0 when `wr_be[0]` is set. A half whose strobe is clear keeps its value.
- R3: Address 0 is the control register. Counter 0's selector is bits 27:20 and counter 1's selector is bits 11:4. A counter increments by exactly one at each clock edge where the strobe `evt[selector]` is high and the context check passes.
- R4: Control bits 0, 1 and 2 enable counting in the user, supervisor and hypervisor contexts. `priv` codes 0, 1 and 2 name those contexts, and code 3 never counts. An event seen in a context whose enable is clear leaves both counters unchanged.
- R5: Counter 0 does not count while its selector holds 0xFF, and counter 1 does not count while its selector holds 0xFE, even if that strobe is high. Each parking code affects only its own counter.
- R6: An increment that takes a counter from 0xFFFFFFFF to 0 sets that counter's overflow flag at the same edge. Address 2 reads the flags: bit 0 for counter 0 and bit 1 for counter 1.
- R7: A write to address 2 with `wr_be[0]` set clears each flag whose data bit is 1 and leaves flags whose data bit is 0. If a wrap and a clear of the same flag happen at one edge, the flag is set.
- R8: `irq` is high exactly when control bit 3 is set and at least one overflow flag is set.
- R9: A counter-half write at the same edge as a qualified event for that counter loads the written value, and the event is lost.
- R10: After a preload of the two's complement of N, the overflow flag rises on exactly the Nth qualified event.
- R11: Control writes need `wr_be[0]` and take `wr_data[31:0]`. Bits 31:28 and 19:12 always read zero, as do read bits 63:32. Address 3 reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 control, 1 counters, 2 flags, 3 unused |
| wr_en | input | 1 | Write request for the addressed register |
| wr_data | input | 64 | Write data |
| wr_be | input | 2 | Write strobe per 32-bit half (bit 1 upper, bit 0 lower) |
| evt | input | 256 | Single-cycle event strobes |
| priv | input | 2 | Current privilege context code |
| rd_data | output | 64 | Read data for the addressed register |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `priv` and `evt` are stable around the rising edge. They also assume that no more than one increment per counter is requested in a cycle, which holds because each counter reads a single strobe. The stimulus drives every input on the falling edge and changes the address only between rising edges, while the clock is low. Random cycles use random context codes, including the reserved code, and dense random strobe vectors. Selectors are drawn from a small set that includes both parking codes, so that wraps, parked counters, context mismatches and loads colliding with events all occur frequently.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
  localparam int unsigned SEL_W       = 8;
  localparam int unsigned CTX_N       = 3;
  localparam int unsigned IRQ_EN_BIT  = 3;
  localparam int unsigned SEL_LO_LSB  = 4;
  localparam int unsigned SEL_UP_LSB  = 20;
  localparam int unsigned CTRL_W      = 32;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 32'h0FF0_0FFF;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_CNT  = 2'd1,
    ADR_FLAG = 2'd2,
    ADR_NONE = 2'd3
  } pmu_adr_e;

  typedef enum logic [1:0] {
    CTX_USR = 2'd0,
    CTX_SUP = 2'd1,
    CTX_HYP = 2'd2,
    CTX_RSV = 2'd3
  } pmu_ctx_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel_up;
    logic [SEL_W-1:0] sel_lo;
    logic             irq_en;
    logic [CTX_N-1:0] ctx_en;
  } pmu_ctrl_t;
endpackage

// File: rtl/pmu_ctrl_regs.sv
`timescale 1ns/1ps
module pmu_ctrl_regs
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CNT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  input  logic                flag_clr_we,
  input  logic [NUM_CNT-1:0]  flag_clr_bits,
  input  logic [NUM_CNT-1:0]  wrap_set,
  output pmu_ctrl_t           ctrl_o,
  output logic [CTRL_W-1:0]   ctrl_raw_o,
  output logic [NUM_CNT-1:0]  flag_o,
  output logic                irq_o
);
  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic [NUM_CNT-1:0] flag_q, flag_d;
  logic [NUM_CNT-1:0] clr_vec;
  logic               flag_en;

  always_comb begin
    ctrl_d  = ctrl_wdata & CTRL_KEEP;
    clr_vec = flag_clr_we ? flag_clr_bits : '0;
    flag_d  = (flag_q & ~clr_vec) | wrap_set;
    flag_en = flag_clr_we | (|wrap_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    ctrl_o.ctx_en = ctrl_q[CTX_N-1:0];
    ctrl_o.irq_en = ctrl_q[IRQ_EN_BIT];
    ctrl_o.sel_lo = ctrl_q[SEL_LO_LSB +: SEL_W];
    ctrl_o.sel_up = ctrl_q[SEL_UP_LSB +: SEL_W];
    ctrl_raw_o    = ctrl_q;
    flag_o        = flag_q;
    irq_o         = ctrl_q[IRQ_EN_BIT] & (|flag_q);
  end

  // A flag stays set unless a clear write hits it.
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_vec)) == $past(flag_q & ~clr_vec)));

  // A wrap always lands in the flag, even against a same-cycle clear.
  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_set) |=> ((flag_q & $past(wrap_set)) == $past(wrap_set)));

  // Control keeps its value when no control write is made.
  assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: rtl/pmu_evt_qual.sv
`timescale 1ns/1ps
module pmu_evt_qual
  import pmu_pkg::*;
#(
  parameter int unsigned         EVT_N = 256,
  parameter logic [SEL_W-1:0]    PARK  = 8'hFF
) (
  input  logic [EVT_N-1:0] evt,
  input  logic [SEL_W-1:0] sel,
  input  logic             ctx_ok,
  output logic             inc
);
  logic in_range;
  logic hit;
  logic parked;

  always_comb begin
    in_range = (int'(sel) < int'(EVT_N));
    hit      = in_range ? evt[sel] : 1'b0;
    parked   = (sel == PARK);
    inc      = hit & ctx_ok & ~parked;
  end
endmodule

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
module pmu_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ld | inc;
    if (ld) begin
      cnt_d = ld_val;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    wrap_o = inc & ~ld & (&cnt_q);
    cnt_o  = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/dual_ctr_pmu.sv
`timescale 1ns/1ps
module dual_ctr_pmu
  import pmu_pkg::*;
#(
  parameter int unsigned      CNT_W   = 32,
  parameter int unsigned      EVT_N   = 256,
  parameter logic [SEL_W-1:0] PARK_UP = 8'hFF,
  parameter logic [SEL_W-1:0] PARK_LO = 8'hFE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           addr,
  input  logic                 wr_en,
  input  logic [2*CNT_W-1:0]   wr_data,
  input  logic [1:0]           wr_be,
  input  logic [EVT_N-1:0]     evt,
  input  logic [1:0]           priv,
  output logic [2*CNT_W-1:0]   rd_data,
  output logic                 irq
);
  localparam int unsigned NUM_CNT = 2;
  localparam int unsigned DATA_W  = NUM_CNT * CNT_W;

  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  pmu_ctrl_t           ctrl;
  logic [CTRL_W-1:0]   ctrl_raw;
  logic [NUM_CNT-1:0]  flags;
  logic [NUM_CNT-1:0]  wraps;
  logic [NUM_CNT-1:0]  loads;
  logic [CNT_W-1:0]    cnt_val [NUM_CNT];
  logic                ctx_ok;
  logic                ctrl_we;
  logic                flag_clr_we;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    ctrl_we     = wr_en & (addr == ADR_CTRL) & wr_be[0];
    flag_clr_we = wr_en & (addr == ADR_FLAG) & wr_be[0];
    unique case (priv)
      CTX_USR: ctx_ok = ctrl.ctx_en[0];
      CTX_SUP: ctx_ok = ctrl.ctx_en[1];
      CTX_HYP: ctx_ok = ctrl.ctx_en[2];
      default: ctx_ok = 1'b0;
    endcase
  end

  pmu_ctrl_regs #(.NUM_CNT(NUM_CNT)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (wr_data[CTRL_W-1:0]),
    .flag_clr_we  (flag_clr_we),
    .flag_clr_bits(wr_data[NUM_CNT-1:0]),
    .wrap_set     (wraps),
    .ctrl_o       (ctrl),
    .ctrl_raw_o   (ctrl_raw),
    .flag_o       (flags),
    .irq_o        (irq)
  );

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    // Counter 0 occupies the upper half, counter 1 the lower half.
    localparam int unsigned      HALF = NUM_CNT - 1 - gi;
    localparam logic [SEL_W-1:0] PARK = (gi == 0) ? PARK_UP : PARK_LO;
    logic [SEL_W-1:0] sel;
    logic             inc;

    assign sel      = (gi == 0) ? ctrl.sel_up : ctrl.sel_lo;
    assign loads[gi] = wr_en & (addr == ADR_CNT) & wr_be[HALF];

    pmu_evt_qual #(.EVT_N(EVT_N), .PARK(PARK)) u_qual (
      .evt   (evt),
      .sel   (sel),
      .ctx_ok(ctx_ok),
      .inc   (inc)
    );

    pmu_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .ld    (loads[gi]),
      .ld_val(wr_data[HALF*CNT_W +: CNT_W]),
      .inc   (inc),
      .cnt_o (cnt_val[gi]),
      .wrap_o(wraps[gi])
    );

    assert_parked_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ((sel == PARK) && !loads[gi]) |=> $stable(cnt_val[gi]));

    assert_rsv_ctx_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ((priv == CTX_RSV) && !loads[gi]) |=> $stable(cnt_val[gi]));
  end

  always_comb begin
    unique case (addr)
      ADR_CTRL: rd_data = DATA_W'(ctrl_raw);
      ADR_CNT:  rd_data = {cnt_val[0], cnt_val[1]};
      ADR_FLAG: rd_data = DATA_W'(flags);
      default:  rd_data = '0;
    endcase
  end

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (flags != '0));
endmodule

// File: tb/dual_ctr_pmu_bench.sv
`timescale 1ns/1ps
module dual_ctr_pmu_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   addr;
  logic         wr_en;
  logic [63:0]  wr_data;
  logic [1:0]   wr_be;
  logic [255:0] evt;
  logic [1:0]   priv;
  logic [63:0]  rd_data;
  logic         irq;

  always #10 clk = ~clk;

  dual_ctr_pmu u_dual_ctr_pmu (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .wr_be(wr_be), .evt(evt), .priv(priv), .rd_data(rd_data), .irq(irq)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] m_ctrl, m_up, m_lo;
  logic [1:0]  m_flag;

  function automatic logic [31:0] mk_ctrl(input logic [7:0] su, input logic [7:0] sl,
                                          input logic ie, input logic [2:0] cx);
    return {4'h0, su, 8'h00, sl, ie, cx};
  endfunction

  function automatic logic [255:0] ev(input int b);
    return 256'd1 << b;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model, applied for one rising edge.
  task automatic model(input logic we, input logic [1:0] a, input logic [63:0] wd,
                       input logic [1:0] be, input logic [255:0] e, input logic [1:0] p);
    logic ok, inc_u, inc_l, ld_u, ld_l;
    logic [1:0] setv, clr;
    logic [7:0] su, sl;
    ok    = (p != 2'd3) && m_ctrl[p];
    su    = m_ctrl[27:20];
    sl    = m_ctrl[11:4];
    inc_u = ok && e[su] && (su != 8'hFF);
    inc_l = ok && e[sl] && (sl != 8'hFE);
    ld_u  = we && a == 2'd1 && be[1];
    ld_l  = we && a == 2'd1 && be[0];
    setv  = {inc_l && !ld_l && m_lo == 32'hFFFF_FFFF, inc_u && !ld_u && m_up == 32'hFFFF_FFFF};
    clr   = (we && a == 2'd2 && be[0]) ? wd[1:0] : 2'b00;
    m_up  = ld_u ? wd[63:32] : (inc_u ? m_up + 1 : m_up);
    m_lo  = ld_l ? wd[31:0]  : (inc_l ? m_lo + 1 : m_lo);
    m_flag = (m_flag & ~clr) | setv;
    if (we && a == 2'd0 && be[0]) m_ctrl = wd[31:0] & 32'h0FF0_0FFF;
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [63:0] wd,
                     input logic [1:0] be, input logic [255:0] e, input logic [1:0] p);
    wr_en = we; addr = a; wr_data = wd; wr_be = be; evt = e; priv = p;
    @(posedge clk);
    model(we, a, wd, be, e, p);
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    wr_en = 1'b0; addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic check_all(input string req);
    logic [63:0] d;
    rd(2'd0, d); chk(req, "ctrl",  d, {32'h0, m_ctrl});
    rd(2'd1, d); chk(req, "count", d, {m_up, m_lo});
    rd(2'd2, d); chk(req, "flags", d, {62'h0, m_flag});
    rd(2'd3, d); chk(req, "unused", d, 64'h0);
    chk(req, "irq", {63'h0, irq}, {63'h0, m_ctrl[3] & (|m_flag)});
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; addr = 0; wr_en = 0; wr_data = 0; wr_be = 0; evt = 0; priv = 0;
    m_ctrl = 0; m_up = 0; m_lo = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_all("R1");
    chk("R1", "irq low", {63'h0, irq}, 64'h0);

    // R2: half writes
    cyc(1, 2'd1, 64'hAAAA_0001_BBBB_0002, 2'b11, '0, 0);
    check_all("R2");
    cyc(1, 2'd1, 64'hCCCC_0003_DDDD_0004, 2'b10, '0, 0);
    rd(2'd1, d); chk("R2", "upper only", d, 64'hCCCC_0003_BBBB_0002);
    cyc(1, 2'd1, 64'hEEEE_0005_1111_0006, 2'b01, '0, 0);
    rd(2'd1, d); chk("R2", "lower only", d, 64'hCCCC_0003_1111_0006);

    // R3: selection
    cyc(1, 2'd1, 64'h0, 2'b11, '0, 0);
    cyc(1, 2'd0, {32'h0, mk_ctrl(8'd5, 8'd9, 1'b0, 3'b001)}, 2'b01, '0, 0);
    cyc(0, 2'd0, 64'h0, 2'b00, ev(5), 2'd0);
    rd(2'd1, d); chk("R3", "upper event", d, 64'h0000_0001_0000_0000);
    cyc(0, 2'd0, 64'h0, 2'b00, ev(9), 2'd0);
    rd(2'd1, d); chk("R3", "lower event", d, 64'h0000_0001_0000_0001);
    check_all("R3");

    // R4: context gating
    cyc(0, 2'd0, 64'h0, 2'b00, ev(5) | ev(9), 2'd1);
    rd(2'd1, d); chk("R4", "sup disabled", d, 64'h0000_0001_0000_0001);
    cyc(1, 2'd0, {32'h0, mk_ctrl(8'd5, 8'd9, 1'b0, 3'b111)}, 2'b01, '0, 0);
    cyc(0, 2'd0, 64'h0, 2'b00, ev(5) | ev(9), 2'd3);
    rd(2'd1, d); chk("R4", "reserved ctx", d, 64'h0000_0001_0000_0001);
    cyc(0, 2'd0, 64'h0, 2'b00, ev(5) | ev(9), 2'd2);
    rd(2'd1, d); chk("R4", "hyp enabled", d, 64'h0000_0002_0000_0002);

    // R5: parking codes, each own only
    cyc(1, 2'd0, {32'h0, mk_ctrl(8'hFF, 8'hFE, 1'b0, 3'b111)}, 2'b01, '0, 0);
    cyc(0, 2'd0, 64'h0, 2'b00, {256{1'b1}}, 2'd0);
    rd(2'd1, d); chk("R5", "both parked", d, 64'h0000_0002_0000_0002);
    cyc(1, 2'd0, {32'h0, mk_ctrl(8'hFE, 8'hFF, 1'b0, 3'b111)}, 2'b01, '0, 0);
    cyc(0, 2'd0, 64'h0, 2'b00, ev(254) | ev(255), 2'd0);
    rd(2'd1, d); chk("R5", "swapped codes count", d, 64'h0000_0003_0000_0003);

    // R10 / R6 / R8: preload -3 on counter 0
    cyc(1, 2'd0, {32'h0, mk_ctrl(8'd5, 8'd9, 1'b1, 3'b001)}, 2'b01, '0, 0);
    cyc(1, 2'd1, {32'hFFFF_FFFD, 32'h0}, 2'b10, '0, 0);
    cyc(0, 2'd0, 64'h0, 2'b00, ev(5), 2'd0);
    cyc(0, 2'd0, 64'h0, 2'b00, ev(5), 2'd0);
    rd(2'd2, d); chk("R10", "no flag after 2", d, 64'h0);
    cyc(0, 2'd0, 64'h0, 2'b00, ev(5), 2'd0);
    rd(2'd2, d); chk("R10", "flag on 3rd", d, 64'h1);
    rd(2'd1, d); chk("R6", "wrapped to zero", d[63:32], 64'h0);
    chk("R8", "irq raised", {63'h0, irq}, 64'h1);
    check_all("R6");

    // R7: set wins over clear at the same edge
    cyc(1, 2'd1, {32'h0, 32'hFFFF_FFFF}, 2'b01, '0, 0);
    cyc(1, 2'd2, 64'h3, 2'b01, ev(9), 2'd0);
    rd(2'd2, d); chk("R7", "set beats clear", d, 64'h2);
    cyc(1, 2'd2, 64'h0, 2'b01, '0, 0);
    rd(2'd2, d); chk("R7", "zero write keeps", d, 64'h2);

    // R8: gate off then on
    cyc(1, 2'd0, {32'h0, mk_ctrl(8'd5, 8'd9, 1'b0, 3'b001)}, 2'b01, '0, 0);
    chk("R8", "irq gated", {63'h0, irq}, 64'h0);
    cyc(1, 2'd0, {32'h0, mk_ctrl(8'd5, 8'd9, 1'b1, 3'b001)}, 2'b01, '0, 0);
    chk("R8", "irq enabled", {63'h0, irq}, 64'h1);
    cyc(1, 2'd2, 64'h2, 2'b01, '0, 0);
    rd(2'd2, d); chk("R7", "cleared", d, 64'h0);
    chk("R8", "irq drop", {63'h0, irq}, 64'h0);

    // R9: load beats event
    cyc(1, 2'd1, 64'h1234_5678_0000_0010, 2'b11, ev(5) | ev(9), 2'd0);
    rd(2'd1, d); chk("R9", "load wins", d, 64'h1234_5678_0000_0010);

    // R11: masked control and dead address
    cyc(1, 2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 2'b01, '0, 0);
    rd(2'd0, d); chk("R11", "ctrl mask", d, 64'h0000_0000_0FF0_0FF0);
    cyc(1, 2'd0, 64'h0000_0000_0000_0001, 2'b10, '0, 0);
    rd(2'd0, d); chk("R11", "ctrl needs be0", d, 64'h0000_0000_0FF0_0FF0);
    cyc(1, 2'd3, {64{1'b1}}, 2'b11, '0, 0);
    check_all("R11");

    // Random mix, all requirements against the model
    for (int n = 0; n < 1500; n++) begin
      logic [255:0] e;
      logic [63:0]  wd;
      logic [7:0]   pick [6];
      int op;
      pick[0] = 8'd0; pick[1] = 8'd1; pick[2] = 8'd7;
      pick[3] = 8'hFE; pick[4] = 8'hFF; pick[5] = 8'd200;
      for (int k = 0; k < 8; k++) e[k*32 +: 32] = $urandom();
      if ($urandom_range(0, 4) == 0) e = '0;
      wd = {$urandom(), $urandom()};
      op = $urandom_range(0, 9);
      case (op)
        0: cyc(1, 2'd0, {wd[63:32], (wd[31:0] & 32'hF00F_F000) |
                 mk_ctrl(pick[$urandom_range(0, 5)], pick[$urandom_range(0, 5)],
                         1'($urandom()), 3'($urandom()))},
               2'($urandom()), e, 2'($urandom()));
        1: cyc(1, 2'd1, {32'hFFFF_FFF8 | 32'($urandom_range(0, 7)),
                         32'hFFFF_FFF8 | 32'($urandom_range(0, 7))},
               2'($urandom()), e, 2'($urandom()));
        2: cyc(1, 2'd2, wd, 2'($urandom()), e, 2'($urandom()));
        3: cyc(1, 2'd3, wd, 2'($urandom()), e, 2'($urandom()));
        default: cyc(0, 2'($urandom()), wd, 2'($urandom()), e, 2'($urandom()));
      endcase
      check_all("R3/R4/R5/R6/R7/R8/R9");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule